// File: doc/BRIEF.md
# Adjustable Time-of-Day Clock

This block keeps a running time of day as a 32-bit seconds count and a nanoseconds count that stays below one billion. Every clock cycle the nanoseconds advance by a nominal increment, and a 32-bit fractional accumulator fed by a programmable rate adds or removes one extra nanosecond on each of its carries. This lets software trim the clock frequency in parts-per-billion steps.

Software talks to the block through a small 16-bit register port. A single time-data register is written as four consecutive words to stage a time value. A command register then either loads that value into the clock or adds it to the running time as a signed offset. A snapshot command freezes the current time so that four reads of the same data register return it. One of several external inputs can be armed so that its next rising edge latches the time once. The captured stamp is then read back as four words.

Top module: `tod_clock`

## Requirements
- R1: Writes to the time-data register (address 0) fill a staged value in the word order ns[15:0], ns[31:16], sec[15:0], sec[31:16]. Any write to the command register (address 1) returns the staging, snapshot-read and event-read pointers to the first word.
- R2: A command write with bit 0 set (load) makes the clock equal the staged value on the following cycle and clears the fractional accumulator. Load takes priority over step.
- R3: A command write with bit 1 set (step) adds the staged value to the clock, on top of that cycle's normal increment. The staged seconds field is two's complement and the staged nanoseconds field must be below 10^9, so a negative offset borrows from seconds.
- R4: A command write with bit 2 set (snapshot) latches the clock value present in that cycle. Successive reads of address 0 then return ns[15:0], ns[31:16], sec[15:0], sec[31:16], and a fifth read wraps to the first word. Read data appears on rdata in the cycle after rd_en and holds until the next read.
- R5: With no command and a zero rate, the clock advances by NOMINAL_NS (8) nanoseconds per cycle. On reaching 10^9, the nanoseconds drop by 10^9 and the seconds increase by one.
- R6: The rate is written as a 26-bit magnitude: bits [9:0] of address 2 hold magnitude[25:16] and address 3 holds magnitude[15:0]. Bit 15 of address 2 set means slower. Each cycle the magnitude is added to the fractional accumulator, and every carry out of it changes that cycle's increment by one nanosecond, down if slower and up otherwise. The magnitude for a given ppb value equals ppb*2^26/1953125, and ±1,953,124 ppb is the largest setting.
- R7: A command write with bit 3 set arms event capture on the input selected by command bits [5:4]. The first rising edge of that input afterwards latches the clock value present in that cycle. Reads of address 4 return it as ns[15:0], ns[31:16], sec[15:0], sec[31:16].
- R8: Capture is single-shot. Once a stamp is taken, further edges leave it unchanged until the block is armed again, and edges on inputs that are not selected have no effect.
- R9: Reading address 5 returns bit 0 = armed and bit 1 = captured, with all other bits zero. Arming sets armed and clears captured, and a capture clears armed.
- R10: After reset the clock, staged value, rate, snapshot, captured stamp, status and rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| ev_in | input | EV_INPUTS | External event inputs, synchronous to clk |

## Verification
The bench builds the block with its defaults: an 8 ns nominal step and four event inputs. With these values the capture path can be swept over every input select, with every non-selected input toggled first. The rate path is exercised at the largest positive and negative settings and at intermediate ones. Over a run of 2000 cycles, the expected carry count (floor of cycles times magnitude over 2^32) comes out exact, including one case that sits just below an integer. Wrap at one second, forward and borrowing steps, and pointer restarts are placed at known cycle offsets, and the expected times are derived from whole-nanosecond totals.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int          DATA_W     = 16;
    localparam int          ADDR_W     = 3;
    localparam int          FRAC_W     = 32;
    localparam int          RATE_W     = 26;
    localparam int          RATE_HI_W  = RATE_W - DATA_W;
    localparam int          SLOW_BIT   = 15;
    localparam logic [31:0] NS_PER_SEC = 32'd1000000000;

    localparam int CMD_LOAD    = 0;
    localparam int CMD_STEP    = 1;
    localparam int CMD_SNAP    = 2;
    localparam int CMD_ARM     = 3;
    localparam int CMD_SEL_LSB = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_TDATA   = 3'd0,
        A_CMD     = 3'd1,
        A_RATE_HI = 3'd2,
        A_RATE_LO = 3'd3,
        A_EVDATA  = 3'd4,
        A_STATUS  = 3'd5
    } tod_addr_e;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] ns;
    } tod_time_t;

    // Adds an offset; the caller keeps both nanosecond terms below one second.
    function automatic tod_time_t tod_add(tod_time_t a, logic [31:0] dns, logic [31:0] dsec);
        tod_time_t   r;
        logic [31:0] s;
        s     = a.ns + dns;
        r.sec = a.sec + dsec;
        if (s >= NS_PER_SEC) begin
            s     = s - NS_PER_SEC;
            r.sec = r.sec + 32'd1;
        end
        r.ns = s;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] tod_word(tod_time_t t, logic [1:0] idx);
        case (idx)
            2'd0:    return t.ns[15:0];
            2'd1:    return t.ns[31:16];
            2'd2:    return t.sec[15:0];
            default: return t.sec[31:16];
        endcase
    endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int NOMINAL_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  tod_time_t         staged,
    input  logic [RATE_W-1:0] rate_mag,
    input  logic              rate_slow,
    output tod_time_t         now
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [31:0]       inc;
    tod_time_t         ticked;
    tod_time_t         stepped;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {{(FRAC_W + 1 - RATE_W){1'b0}}, rate_mag};
        inc     = 32'(NOMINAL_NS);
        if (acc_sum[FRAC_W]) begin
            inc = rate_slow ? inc - 32'd1 : inc + 32'd1;
        end
        ticked  = tod_add(now, inc, 32'd0);
        stepped = tod_add(ticked, staged.ns, staged.sec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now   <= '0;
            acc_q <= '0;
        end else if (load) begin
            now   <= staged;
            acc_q <= '0;
        end else begin
            acc_q <= acc_sum[FRAC_W-1:0];
            now   <= step ? stepped : ticked;
        end
    end

endmodule

// File: rtl/tod_capture.sv
module tod_capture
    import tod_pkg::*;
#(
    parameter int EV_INPUTS = 4,
    localparam int SEL_W = (EV_INPUTS > 1) ? $clog2(EV_INPUTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EV_INPUTS-1:0] ev_in,
    input  logic                 arm,
    input  logic [SEL_W-1:0]     arm_sel,
    input  tod_time_t            now,
    output logic                 armed,
    output logic                 captured,
    output tod_time_t            cap_time
);

    logic [EV_INPUTS-1:0] ev_q;
    logic [EV_INPUTS-1:0] rise;
    logic [SEL_W-1:0]     sel_q;

    assign rise = ev_in & ~ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q     <= '0;
            sel_q    <= '0;
            armed    <= 1'b0;
            captured <= 1'b0;
            cap_time <= '0;
        end else begin
            ev_q <= ev_in;
            if (arm) begin
                armed    <= 1'b1;
                captured <= 1'b0;
                sel_q    <= arm_sel;
            end else if (armed && rise[sel_q]) begin
                armed    <= 1'b0;
                captured <= 1'b1;
                cap_time <= now;
            end
        end
    end

endmodule

// File: rtl/tod_regif.sv
module tod_regif
    import tod_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  tod_time_t         now,
    input  tod_time_t         cap_time,
    input  logic              armed,
    input  logic              captured,
    output tod_time_t         staged,
    output logic              load_p,
    output logic              step_p,
    output logic              arm_p,
    output logic [SEL_W-1:0]  arm_sel,
    output logic [RATE_W-1:0] rate_mag,
    output logic              rate_slow
);

    logic                 cmd_wr;
    logic [1:0]           wptr, rptr, eptr;
    tod_time_t            snap_q;
    logic [RATE_HI_W-1:0] rate_hi_q;
    logic [DATA_W-1:0]    rate_lo_q;

    assign cmd_wr   = wr_en && (addr == A_CMD);
    assign load_p   = cmd_wr && wdata[CMD_LOAD];
    assign step_p   = cmd_wr && wdata[CMD_STEP];
    assign arm_p    = cmd_wr && wdata[CMD_ARM];
    assign arm_sel  = wdata[CMD_SEL_LSB +: SEL_W];
    assign rate_mag = {rate_hi_q, rate_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            rptr      <= '0;
            eptr      <= '0;
            staged    <= '0;
            snap_q    <= '0;
            rate_hi_q <= '0;
            rate_lo_q <= '0;
            rate_slow <= 1'b0;
            rdata     <= '0;
        end else begin
            if (cmd_wr) begin
                wptr <= '0;
                rptr <= '0;
                eptr <= '0;
                if (wdata[CMD_SNAP]) snap_q <= now;
            end else begin
                if (wr_en && addr == A_TDATA) begin
                    case (wptr)
                        2'd0:    staged.ns[15:0]   <= wdata;
                        2'd1:    staged.ns[31:16]  <= wdata;
                        2'd2:    staged.sec[15:0]  <= wdata;
                        default: staged.sec[31:16] <= wdata;
                    endcase
                    wptr <= wptr + 2'd1;
                end
                if (rd_en && addr == A_TDATA)  rptr <= rptr + 2'd1;
                if (rd_en && addr == A_EVDATA) eptr <= eptr + 2'd1;
            end
            if (wr_en && addr == A_RATE_HI) begin
                rate_hi_q <= wdata[RATE_HI_W-1:0];
                rate_slow <= wdata[SLOW_BIT];
            end
            if (wr_en && addr == A_RATE_LO) rate_lo_q <= wdata;
            if (rd_en) begin
                case (addr)
                    A_TDATA:  rdata <= tod_word(snap_q, rptr);
                    A_EVDATA: rdata <= tod_word(cap_time, eptr);
                    A_STATUS: rdata <= {{(DATA_W - 2){1'b0}}, captured, armed};
                    default:  rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int NOMINAL_NS = 8,
    parameter int EV_INPUTS  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [2:0]           addr,
    input  logic [15:0]          wdata,
    output logic [15:0]          rdata,
    input  logic [EV_INPUTS-1:0] ev_in
);

    localparam int SEL_W = (EV_INPUTS > 1) ? $clog2(EV_INPUTS) : 1;

    tod_time_t         now, staged, cap_time;
    logic              load_p, step_p, arm_p;
    logic [SEL_W-1:0]  arm_sel;
    logic [RATE_W-1:0] rate_mag;
    logic              rate_slow;
    logic              armed, captured;

    tod_regif #(.SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .now(now), .cap_time(cap_time),
        .armed(armed), .captured(captured), .staged(staged), .load_p(load_p),
        .step_p(step_p), .arm_p(arm_p), .arm_sel(arm_sel),
        .rate_mag(rate_mag), .rate_slow(rate_slow)
    );

    tod_counter #(.NOMINAL_NS(NOMINAL_NS)) u_cnt (
        .clk(clk), .rst(rst), .load(load_p), .step(step_p), .staged(staged),
        .rate_mag(rate_mag), .rate_slow(rate_slow), .now(now)
    );

    tod_capture #(.EV_INPUTS(EV_INPUTS)) u_cap (
        .clk(clk), .rst(rst), .ev_in(ev_in), .arm(arm_p), .arm_sel(arm_sel),
        .now(now), .armed(armed), .captured(captured), .cap_time(cap_time)
    );

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int NOMINAL_NS = 8
) (
    input logic              clk,
    input logic              rst,
    input tod_time_t         now,
    input tod_time_t         staged,
    input logic              load_p,
    input logic              step_p,
    input logic              arm_p,
    input logic [RATE_W-1:0] rate_mag,
    input logic              armed,
    input logic              captured,
    input tod_time_t         cap_time
);

    a_r5_ns_range: assert property (@(posedge clk) disable iff (rst)
        now.ns < NS_PER_SEC);

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        load_p |=> (now == $past(staged)));

    a_r5_tick: assert property (@(posedge clk) disable iff (rst)
        (!load_p && !step_p && rate_mag == '0 && now.ns < NS_PER_SEC - 32'(NOMINAL_NS))
        |=> (now.ns == $past(now.ns) + 32'(NOMINAL_NS) && now.sec == $past(now.sec)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (captured && !arm_p) |=> (captured && $stable(cap_time)));

    a_r9_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({armed, captured}));

endmodule

bind tod_clock tod_clock_chk #(.NOMINAL_NS(NOMINAL_NS)) u_chk (
    .clk(clk), .rst(rst), .now(now), .staged(staged), .load_p(load_p),
    .step_p(step_p), .arm_p(arm_p), .rate_mag(rate_mag), .armed(armed),
    .captured(captured), .cap_time(cap_time)
);

// File: tb/sim_tod_clock.sv
module sim_tod_clock;

    localparam longint NS1 = 64'd1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  ev_in = '0;

    int checks = 0;
    int fails  = 0;

    tod_clock u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .ev_in(ev_in));

    always #10 clk = ~clk;

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stage(logic [31:0] s, logic [31:0] n);
        wr(3'd0, n[15:0]); wr(3'd0, n[31:16]); wr(3'd0, s[15:0]); wr(3'd0, s[31:16]);
    endtask

    task automatic read4(logic [2:0] a, output logic [63:0] t);
        logic [15:0] w0, w1, w2, w3;
        rd(a, w0); rd(a, w1); rd(a, w2); rd(a, w3);
        t = {w3, w2, w1, w0};
    endtask

    function automatic logic [63:0] split(longint tot);
        logic [31:0] s, n;
        s = 32'(tot / NS1);
        n = 32'(tot % NS1);
        return {s, n};
    endfunction

    task automatic snap_chk(string req, longint exp);
        logic [63:0] t;
        wr(3'd1, 16'h0004);
        read4(3'd0, t);
        chk(req, t, split(exp));
    endtask

    task automatic set_rate(longint ppb);
        longint mag;
        logic   slow;
        slow = ppb < 0;
        mag  = ((slow ? -ppb : ppb) * 64'd67108864) / 64'd1953125;
        wr(3'd2, {slow, 5'd0, 10'(mag >> 16)});
        wr(3'd3, 16'(mag));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [63:0] t;
        longint      base;
        longint      ppbs[5];
        ppbs = '{64'sd1953124, -64'sd1953124, 64'sd1000000, -64'sd1000000, 64'sd1};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 rdata", {48'd0, rdata}, 64'd0);
        rd(3'd5, v); chk("R10 R9 status", {48'd0, v}, 64'd0);
        read4(3'd0, t); chk("R10 snapshot", t, 64'd0);
        read4(3'd4, t); chk("R10 stamp", t, 64'd0);

        // R2 load then R5 ticks
        stage(32'd3, 32'd1000); wr(3'd1, 16'h0001); idle(10);
        snap_chk("R2 load R5 tick", 3 * NS1 + 1000 + 80);

        // R4 word order and wrap
        stage(32'h12345678, 32'h23456789); wr(3'd1, 16'h0001);
        wr(3'd1, 16'h0004);
        rd(3'd0, v); chk("R4 word0", {48'd0, v}, 64'h6789);
        rd(3'd0, v); chk("R4 word1", {48'd0, v}, 64'h2345);
        rd(3'd0, v); chk("R4 word2", {48'd0, v}, 64'h5678);
        rd(3'd0, v); chk("R4 word3", {48'd0, v}, 64'h1234);
        rd(3'd0, v); chk("R4 wrap", {48'd0, v}, 64'h6789);

        // R5 second wrap
        stage(32'd5, 32'd999999990); wr(3'd1, 16'h0001); idle(2);
        snap_chk("R5 wrap", 5 * NS1 + 999999990 + 16);

        // R1 pointer restart on command write
        wr(3'd0, 16'hAAAA); wr(3'd0, 16'h5555); wr(3'd1, 16'h0000);
        stage(32'd2, 32'd777); wr(3'd1, 16'h0001);
        snap_chk("R1 pointer reset", 2 * NS1 + 777);

        // R3 forward step (5 ticks to and including the step edge)
        base = 1 * NS1 + 600000000;
        stage(32'd1, 32'd600000000); wr(3'd1, 16'h0001);
        stage(32'd2, 32'd500000000); wr(3'd1, 16'h0002);
        snap_chk("R3 step fwd", base + 40 + 2 * NS1 + 500000000);

        // R3 negative step borrowing from seconds (-100 ns)
        base = 10 * NS1 + 20;
        stage(32'd10, 32'd20); wr(3'd1, 16'h0001);
        stage(32'hFFFFFFFF, 32'd999999900); wr(3'd1, 16'h0002);
        snap_chk("R3 step borrow", base + 40 - 100);

        // R6 rate sweep over 2000 cycles from zero
        foreach (ppbs[i]) begin
            longint mag, carries;
            mag     = ((ppbs[i] < 0 ? -ppbs[i] : ppbs[i]) * 64'd67108864) / 64'd1953125;
            carries = (2000 * mag) / 64'd4294967296;
            set_rate(ppbs[i]);
            stage(32'd0, 32'd0); wr(3'd1, 16'h0001); idle(2000);
            snap_chk("R6 rate", 16000 + (ppbs[i] < 0 ? -carries : carries));
        end
        set_rate(0);

        // R7 R8 R9 capture sweep over every input select
        for (int sel = 0; sel < 4; sel++) begin
            logic [63:0] expt;
            wr(3'd1, 16'((sel << 4) | 8));
            for (int j = 0; j < 4; j++) begin
                if (j != sel) begin
                    ev_in = 4'(1 << j); idle(1); ev_in = '0; idle(1);
                end
            end
            rd(3'd5, v); chk("R8 R9 unselected ignored", {48'd0, v}, 64'd1);
            stage(32'd7, 32'(100 + sel)); wr(3'd1, 16'h0001); idle(2);
            ev_in = 4'(1 << sel); idle(1); ev_in = '0; idle(1);
            expt = split(7 * NS1 + 100 + sel + 16);
            ev_in = 4'(1 << sel); idle(1); ev_in = '0; idle(1);
            rd(3'd5, v); chk("R9 captured status", {48'd0, v}, 64'd2);
            read4(3'd4, t); chk("R7 R8 stamp", t, expt);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule